// File: doc/BRIEF.md
# ATM Cell Receive Reader (Single PHY)

This block sits on the ATM-layer side of a single-PHY receive cell bus. It watches the cell-available flag driven by the PHY, drives an active-low read enable, and samples one byte or one 16-bit word per enabled transfer. Each transfer is checked for odd parity, and each cell is checked for a correctly placed start-of-cell marker. The accepted transfers go out as a valid/data/last stream, with sticky parity-error and framing-error flags attached.

Two handshake styles are selected by a static input. In transfer-by-transfer mode, every read is gated by the flag seen on the previous edge, so a cell can pause part-way through. In whole-cell mode, the reader commits to a full cell once it starts. It checks the flag only while issuing the final read of the cell, and uses that value to decide whether to continue into the next cell or go idle.

Top module: `utopia_rx_reader`

## Requirements
- R1: While the asynchronous active-low reset `rst_ni` is low, `rx_en_no` is high and `out_valid_o` is low. After reset the cell position restarts at the first transfer of a cell.
- R2: `rx_en_no` falls only at an edge where `rx_clav_i` was sampled high. It never goes low while the flag has been low.
- R3: With `cell_mode_i`=0 (transfer-by-transfer), `rx_en_no` in each cycle is the inverse of `rx_clav_i` sampled at the preceding edge. A low flag pauses a cell mid-way.
- R4: With `cell_mode_i`=1 (whole-cell), every run of low `rx_en_no` is a whole number of cells. A cell is 53 transfers at `DATA_W`=8, or 27 at `DATA_W`=16. Changes of `rx_clav_i` inside a cell have no effect. The flag sampled at the edge ending the cell's final enable cycle either keeps the enable low for the next cell or releases it.
- R5: Bus data is sampled at the edge one cycle after a cycle with `rx_en_no` low, and never at the edge where the enable falls. Each sampled transfer appears on `out_valid_o`/`out_data_o` in the following cycle, with the data unchanged. At 16-bit width, the low byte of a cell's final word is padding and is output as zero.
- R6: `out_last_o` is high exactly on output beat number 52 (8-bit) or 26 (16-bit) of each cell, counting from 0. Cell boundaries are counted from reset.
- R7: Parity is odd: `rx_data_i` together with `rx_prty_i` must contain an odd number of ones. A mismatch raises `out_perr_o` on that beat and keeps it high through the cell's last beat.
- R8: `rx_soc_i` must be 1 on a cell's first transfer and 0 on all of its other transfers. Any deviation raises `out_ferr_o` on that beat and keeps it high through the cell's last beat.
- R9: Both error flags are held between beats. They start clean on the first beat of the next cell and change only on a valid beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cell_mode_i | input | 1 | 0: transfer-by-transfer handshake, 1: whole-cell handshake (static) |
| rx_clav_i | input | 1 | PHY has cell data available |
| rx_soc_i | input | 1 | Start-of-cell marker from PHY |
| rx_data_i | input | DATA_W | Cell data bus |
| rx_prty_i | input | 1 | Odd parity bit over rx_data_i |
| rx_en_no | output | 1 | Read enable to PHY, active low |
| out_valid_o | output | 1 | Output beat valid |
| out_data_o | output | DATA_W | Output beat data |
| out_last_o | output | 1 | Final beat of a cell |
| out_perr_o | output | 1 | Parity error seen in this cell so far |
| out_ferr_o | output | 1 | Start-of-cell framing error seen in this cell so far |

## Verification
A corrupted transfer counter shows up within one cell: `out_last_o` lands on the wrong beat, and a correct start-of-cell marker is reported as `out_ferr_o` on the next beat. A wrong handshake state shows up at `rx_en_no` one edge after the flag changes. In whole-cell mode it shows up as an enable run that ends part-way through a cell. Sampling the bus in the wrong cycle produces mismatched data and spurious parity errors on the very first beat.

// File: rtl/utopia_rx_pkg.sv
package utopia_rx_pkg;
  typedef enum logic {
    RD_IDLE = 1'b0,
    RD_CELL = 1'b1
  } rd_state_e;

  function automatic int unsigned cell_xfers(input int unsigned data_w);
    return (data_w == 16) ? 27 : 53;
  endfunction
endpackage

// File: rtl/utopia_rx_req_ctrl.sv
module utopia_rx_req_ctrl
  import utopia_rx_pkg::*;
#(
  parameter int unsigned XFERS = 53,
  localparam int unsigned CNT_W = $clog2(XFERS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cell_mode_i,
  input  logic clav_i,
  output logic rd_en_o
);
  localparam logic [CNT_W-1:0] LAST_REQ = CNT_W'(XFERS - 1);

  rd_state_e        state_q;
  logic [CNT_W-1:0] req_cnt_q;
  logic             en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RD_IDLE;
      req_cnt_q <= '0;
      en_q      <= 1'b0;
    end else if (!cell_mode_i) begin
      // transfer-by-transfer: each read gated by flag of previous edge
      state_q   <= RD_IDLE;
      req_cnt_q <= '0;
      en_q      <= clav_i;
    end else begin
      unique case (state_q)
        RD_IDLE: begin
          req_cnt_q <= '0;
          if (clav_i) begin
            en_q    <= 1'b1;
            state_q <= RD_CELL;
          end else begin
            en_q    <= 1'b0;
          end
        end
        RD_CELL: begin
          if (req_cnt_q == LAST_REQ) begin
            req_cnt_q <= '0;
            if (!clav_i) begin
              en_q    <= 1'b0;
              state_q <= RD_IDLE;
            end
          end else begin
            req_cnt_q <= req_cnt_q + 1'b1;
          end
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end

  assign rd_en_o = en_q;
endmodule

// File: rtl/utopia_rx_beat_check.sv
module utopia_rx_beat_check #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned XFERS  = 53,
  localparam int unsigned CNT_W = $clog2(XFERS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              soc_i,
  input  logic              prty_i,
  output logic [DATA_W-1:0] data_o,
  output logic              last_o,
  output logic              perr_o,
  output logic              ferr_o
);
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(XFERS - 1);

  logic [CNT_W-1:0] beat_cnt_q;
  logic             perr_acc_q, ferr_acc_q;
  logic             first;

  assign first  = (beat_cnt_q == '0);
  assign last_o = (beat_cnt_q == LAST_BEAT);
  assign perr_o = perr_acc_q | ~(^{data_i, prty_i});
  assign ferr_o = ferr_acc_q | (soc_i != first);

  generate
    if (DATA_W > 8) begin : g_pad
      // low byte of final word is padding
      assign data_o = last_o ? {data_i[DATA_W-1:8], 8'h00} : data_i;
    end else begin : g_nopad
      assign data_o = data_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_cnt_q <= '0;
      perr_acc_q <= 1'b0;
      ferr_acc_q <= 1'b0;
    end else if (smp_i) begin
      if (last_o) begin
        beat_cnt_q <= '0;
        perr_acc_q <= 1'b0;
        ferr_acc_q <= 1'b0;
      end else begin
        beat_cnt_q <= beat_cnt_q + 1'b1;
        perr_acc_q <= perr_o;
        ferr_acc_q <= ferr_o;
      end
    end
  end
endmodule

// File: rtl/utopia_rx_out_reg.sv
module utopia_rx_out_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              beat_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              last_i,
  input  logic              perr_i,
  input  logic              ferr_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              last_o,
  output logic              perr_o,
  output logic              ferr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      last_o  <= 1'b0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      valid_o <= beat_i;
      last_o  <= beat_i & last_i;
      if (beat_i) begin
        data_o <= data_i;
        perr_o <= perr_i;
        ferr_o <= ferr_i;
      end
    end
  end
endmodule

// File: rtl/utopia_rx_reader.sv
module utopia_rx_reader
  import utopia_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cell_mode_i,
  input  logic              rx_clav_i,
  input  logic              rx_soc_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_prty_i,
  output logic              rx_en_no,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_last_o,
  output logic              out_perr_o,
  output logic              out_ferr_o
);
  localparam int unsigned XFERS = cell_xfers(DATA_W);

  logic              rd_en;
  logic              smp_q;
  logic [DATA_W-1:0] beat_data;
  logic              beat_last, beat_perr, beat_ferr;

  utopia_rx_req_ctrl #(.XFERS(XFERS)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cell_mode_i(cell_mode_i),
    .clav_i     (rx_clav_i),
    .rd_en_o    (rd_en)
  );

  // PHY drives the bus the cycle after it sees enable low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smp_q <= 1'b0;
    else         smp_q <= rd_en;
  end

  utopia_rx_beat_check #(.DATA_W(DATA_W), .XFERS(XFERS)) u_chk_beat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .smp_i (smp_q),
    .data_i(rx_data_i),
    .soc_i (rx_soc_i),
    .prty_i(rx_prty_i),
    .data_o(beat_data),
    .last_o(beat_last),
    .perr_o(beat_perr),
    .ferr_o(beat_ferr)
  );

  utopia_rx_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .beat_i (smp_q),
    .data_i (beat_data),
    .last_i (beat_last),
    .perr_i (beat_perr),
    .ferr_i (beat_ferr),
    .valid_o(out_valid_o),
    .data_o (out_data_o),
    .last_o (out_last_o),
    .perr_o (out_perr_o),
    .ferr_o (out_ferr_o)
  );

  assign rx_en_no = ~rd_en;
endmodule

// File: rtl/utopia_rx_reader_chk.sv
module utopia_rx_reader_chk #(
  parameter int unsigned XFERS = 53
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cell_mode_i,
  input logic rx_clav_i,
  input logic rx_en_no,
  input logic out_valid_o,
  input logic out_last_o,
  input logic out_perr_o,
  input logic out_ferr_o
);
  localparam int unsigned RW = $clog2(XFERS + 1);

  logic [RW-1:0] run_q;
  logic [1:0]    en_hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= '0;
      en_hist_q <= '0;
    end else begin
      en_hist_q <= {en_hist_q[0], ~rx_en_no};
      if (!rx_en_no) run_q <= (run_q == RW'(XFERS - 1)) ? '0 : run_q + 1'b1;
    end
  end

  // R1
  rst_idle_chk: assert property (@(posedge clk_i) !rst_ni |-> rx_en_no && !out_valid_o);

  // R2
  en_after_clav_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_en_no) |-> $past(rx_clav_i));

  // R3
  octet_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cell_mode_i && $past(rst_ni) |-> rx_en_no == !$past(rx_clav_i));

  // R4
  whole_cell_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_mode_i && $rose(rx_en_no) |-> run_q == '0);

  // R5
  beat_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> en_hist_q[1]);

  // R6
  last_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o);

  // R9
  perr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(out_perr_o) && $stable(out_ferr_o));
endmodule

bind utopia_rx_reader utopia_rx_reader_chk #(.XFERS(XFERS)) u_rx_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cell_mode_i(cell_mode_i),
  .rx_clav_i  (rx_clav_i),
  .rx_en_no   (rx_en_no),
  .out_valid_o(out_valid_o),
  .out_last_o (out_last_o),
  .out_perr_o (out_perr_o),
  .out_ferr_o (out_ferr_o)
);

// File: tb/tb_utopia_rx_reader.sv
`timescale 1ns/1ps
module tb_utopia_rx_reader;
  localparam int XF = 53;
  localparam int NSC = 6;
  // scenario table: mode, clav on, clav off, run cycles, parity-error idx, soc-error idx
  localparam int SC_MODE[NSC] = '{0, 0, 1, 1, 0, 1};
  localparam int SC_ON  [NSC] = '{1, 3, 1, 1, 2, 5};
  localparam int SC_OFF [NSC] = '{0, 2, 0, 0, 3, 40};
  localparam int SC_RUN [NSC] = '{150, 300, 150, 120, 300, 300};
  localparam int SC_PAR [NSC] = '{-1, 5, -1, -1, -1, 60};
  localparam int SC_SOC [NSC] = '{-1, -1, -1, 0, 17, -1};

  logic clk = 0, rst_n = 0, mode = 0, clav = 0, soc = 0, prty = 0;
  logic [7:0] data = 0;
  logic en_n, ov, olast, operr, oferr;
  logic [7:0] odata;

  int checks = 0, fails = 0, cyc = 0;
  int idx = 0, rx_beat = 0, par_pos = -1, soc_pos = -1, edges = 0;
  bit pend = 0, clav_prev = 0;

  always #2.5 clk = ~clk;

  utopia_rx_reader #(.DATA_W(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cell_mode_i(mode), .rx_clav_i(clav),
    .rx_soc_i(soc), .rx_data_i(data), .rx_prty_i(prty), .rx_en_no(en_n),
    .out_valid_o(ov), .out_data_o(odata), .out_last_o(olast),
    .out_perr_o(operr), .out_ferr_o(oferr)
  );

  function automatic logic [7:0] byte_of(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // PHY model: answers an enable seen at an edge with data in the next cycle
  always @(posedge clk) begin
    pend      <= rst_n && !en_n;
    clav_prev <= clav;
    edges     <= rst_n ? edges + 1 : 0;
    cyc       <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      idx = 0; data = 0; soc = 0; prty = 0;
    end else if (pend) begin
      data = byte_of(idx);
      soc  = ((idx % XF) == 0) ^ (idx == soc_pos);
      prty = (~^byte_of(idx)) ^ (idx == par_pos);
      idx  = idx + 1;
    end else begin
      data = 8'h00; soc = 0; prty = 0;
    end
  end

  // output monitor (R5 R6 R7 R8 R9) and handshake monitor (R3)
  always @(negedge clk) begin
    if (!rst_n) rx_beat = 0;
    else begin
      if (ov) begin
        int c;
        bit el, ep, ef;
        c  = rx_beat / XF;
        el = (rx_beat % XF) == XF - 1;
        ep = par_pos >= c * XF && par_pos <= rx_beat;
        ef = soc_pos >= c * XF && soc_pos <= rx_beat;
        chk({odata, olast, operr, oferr} == {byte_of(rx_beat), el, ep, ef},
            "R5/R6/R7/R8/R9 beat", {odata, olast, operr, oferr},
            {byte_of(rx_beat), el, ep, ef});
        rx_beat = rx_beat + 1;
      end
      if (!mode && edges > 0)
        chk(en_n == !clav_prev, "R3 enable follows flag", en_n, !clav_prev);
    end
  end

  task automatic do_reset();
    rst_n = 0; clav = 0;
    repeat (3) @(negedge clk);
    chk(en_n == 1'b1 && ov == 1'b0, "R1 reset idle", {en_n, ov}, 2'b10);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic drain_and_check(input bit whole);
    @(negedge clk); clav = 0;
    repeat (120) @(negedge clk);
    @(posedge clk); #1;
    chk(rx_beat == idx, "R5 all transfers delivered", rx_beat, idx);
    chk(en_n == 1'b1, "R2 idle when flag low", en_n, 1);
    chk(idx > 0, "R2 progress", idx, 1);
    if (whole) chk((idx % XF) == 0, "R4 whole cells in cell mode", idx % XF, 0);
  endtask

  initial begin
    for (int s = 0; s < NSC; s++) begin
      mode = SC_MODE[s][0]; par_pos = SC_PAR[s]; soc_pos = SC_SOC[s];
      do_reset();
      for (int k = 0; k < SC_RUN[s]; k++) begin
        clav = (k % (SC_ON[s] + SC_OFF[s])) < SC_ON[s];
        @(negedge clk);
      end
      drain_and_check(mode);
    end

    // R4: one-cycle flag pulse in cell mode reads exactly one cell
    mode = 1; par_pos = -1; soc_pos = -1;
    do_reset();
    clav = 1; @(negedge clk); clav = 0;
    drain_and_check(1);
    chk(idx == XF, "R4 single cell on pulse", idx, XF);

    // R3: one-cycle flag pulse in octet mode reads one transfer
    mode = 0;
    do_reset();
    clav = 1; @(negedge clk); clav = 0;
    drain_and_check(0);
    chk(idx == 1, "R3 single transfer on pulse", idx, 1);

    // R2: flag low keeps enable high
    do_reset();
    repeat (10) @(negedge clk);
    chk(en_n == 1'b1 && idx == 0, "R2 no read while flag low", idx, 0);

    // R1: reset mid-cell restarts cell position; monitor expects clean cell
    mode = 1;
    do_reset();
    clav = 1; repeat (20) @(negedge clk);
    do_reset();
    clav = 1; @(negedge clk); clav = 0;
    drain_and_check(1);
    chk(idx == XF, "R1 clean restart after reset", idx, XF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule